// File: doc/BRIEF.md
# Vector Upper-Half Merge Injector

This block sits in the in-order dispatch stage of a vector pipeline whose sixteen architectural registers each hold a 128-bit lower half and a 128-bit upper half. One decoded instruction arrives per cycle, with a class code, a destination register index and an opaque payload. The block keeps a dirty bit for each register's upper half. From the OR of those bits it decides whether a legacy 128-bit write needs extra work downstream.

While every upper half is known to be zero, a legacy 128-bit write passes straight through. Once any upper half may hold data, the block marks each legacy 128-bit write as dependent on the old value of its destination. It then follows that write with an injected merge micro-op, which blends the preserved upper half back into the new result. During the cycle in which the merge micro-op is offered, upstream ready is held low, so both micro-ops leave in program order. A saturating counter counts the merge micro-ops delivered downstream.

Top module: `vupper_merge_inject`

## Requirements
- R1: After reset, all upper halves are clean, no micro-op is offered, the merge count is zero, and a legacy 128-bit write (class 0) passes through with dependency flag 0 and no merge micro-op.
- R2: While any dirty bit is set, a legacy 128-bit write is passed on with dependency flag 1. In the next cycle it is followed by a merge micro-op (merge flag 1, class 0, dependency flag 1) that carries the same destination and payload.
- R3: A 256-bit write (class 2) sets the dirty bit of its destination, so a later legacy write to any register gets a merge micro-op.
- R4: A prefixed 128-bit write (class 1) never gets a merge micro-op or a dependency flag, and it clears the dirty bit of its own destination only.
- R5: The merge decision uses the OR of all sixteen dirty bits, not the destination's own bit. A legacy write to a clean register still gets a merge micro-op while another register is dirty.
- R6: A zero-upper instruction (class 3) clears every dirty bit. The next legacy write then passes with no merge micro-op.
- R7: A zero-all instruction (class 4) clears every dirty bit in the same way as class 3.
- R8: While a merge micro-op is offered, upstream ready is low. A merge micro-op that is stalled by downstream ready stays offered with stable fields until downstream accepts it.
- R9: The merge count rises by one for each merge micro-op that downstream accepts, and it holds at its maximum value instead of wrapping.
- R10: Classes 5 to 7 pass through unchanged with dependency flag 0 and leave the dirty bits untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream instruction valid |
| in_ready | output | 1 | Upstream may advance |
| in_cls | input | 3 | Instruction class: 0 legacy 128, 1 prefixed 128, 2 wide 256, 3 zero-upper, 4 zero-all, 5-7 other |
| in_dst | input | 4 | Destination register index |
| in_pay | input | PAY_W | Opaque instruction payload |
| out_valid | output | 1 | Micro-op valid downstream |
| out_ready | input | 1 | Downstream accepts |
| out_merge | output | 1 | Micro-op is an injected merge |
| out_cls | output | 3 | Class of the micro-op |
| out_dst | output | 4 | Destination register index |
| out_dep | output | 1 | Micro-op must wait for the old destination value |
| out_pay | output | PAY_W | Payload carried with the micro-op |
| merge_count | output | CNT_W | Saturating count of delivered merge micro-ops |

## Verification
Legacy writes are sent in the clean state, after a wide write to the same register, and after a wide write to a different register. Together these separate a global-condition design from a per-destination one. Prefixed writes are sent to the dirty register and to a clean one, to show that a prefixed write clears only its own bit. Zero-upper and zero-all are each tried as the way back to the clean state, and classes 5 to 7 are tried as passive. A downstream stall during a merge, followed by a long run of merges, exercises the hold-off of upstream ready and the counter's saturation.

// File: rtl/vmi_pkg.sv
package vmi_pkg;
    localparam logic [2:0] CLS_LEG128  = 3'd0;
    localparam logic [2:0] CLS_VEX128  = 3'd1;
    localparam logic [2:0] CLS_WIDE256 = 3'd2;
    localparam logic [2:0] CLS_ZUPPER  = 3'd3;
    localparam logic [2:0] CLS_ZALL    = 3'd4;
endpackage

// File: rtl/vmi_dirty_track.sv
module vmi_dirty_track
    import vmi_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [2:0]       cls,
    input  logic [IDX_W-1:0] dst,
    output logic             dirty_any
);
    typedef struct packed {
        logic [NREG-1:0] dirty;
    } trk_t;

    trk_t            s_q, s_d;
    logic [NREG-1:0] bit_d;
    logic            clr_all;

    assign clr_all = upd_en && (cls == CLS_ZUPPER || cls == CLS_ZALL);

    for (genvar i = 0; i < NREG; i++) begin : g_bit
        logic hit;
        assign hit = upd_en && (dst == IDX_W'(i));
        always_comb begin
            bit_d[i] = s_q.dirty[i];
            if (clr_all)
                bit_d[i] = 1'b0;
            else if (hit && cls == CLS_WIDE256)
                bit_d[i] = 1'b1;
            else if (hit && cls == CLS_VEX128)
                bit_d[i] = 1'b0;
        end
    end

    always_comb begin
        s_d.dirty = bit_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dirty_any = |s_q.dirty;
endmodule

// File: rtl/vmi_merge_seq.sv
module vmi_merge_seq
    import vmi_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int PAY_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dirty_any,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [2:0]       in_cls,
    input  logic [IDX_W-1:0] in_dst,
    input  logic [PAY_W-1:0] in_pay,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_merge,
    output logic [2:0]       out_cls,
    output logic [IDX_W-1:0] out_dst,
    output logic             out_dep,
    output logic [PAY_W-1:0] out_pay,
    output logic             accept,
    output logic             merge_fire
);
    typedef struct packed {
        logic             pend;
        logic [IDX_W-1:0] dst;
        logic [PAY_W-1:0] pay;
    } seq_t;

    seq_t s_q, s_d;
    logic need_merge;

    assign need_merge = (in_cls == CLS_LEG128) && dirty_any;

    always_comb begin
        s_d        = s_q;
        accept     = 1'b0;
        merge_fire = 1'b0;
        if (s_q.pend) begin
            in_ready   = 1'b0;
            out_valid  = 1'b1;
            out_merge  = 1'b1;
            out_cls    = CLS_LEG128;
            out_dst    = s_q.dst;
            out_dep    = 1'b1;
            out_pay    = s_q.pay;
            merge_fire = out_ready;
            if (out_ready) s_d.pend = 1'b0;
        end else begin
            in_ready  = out_ready;
            out_valid = in_valid;
            out_merge = 1'b0;
            out_cls   = in_cls;
            out_dst   = in_dst;
            out_dep   = need_merge;
            out_pay   = in_pay;
            accept    = in_valid && out_ready;
            if (accept && need_merge) begin
                s_d.pend = 1'b1;
                s_d.dst  = in_dst;
                s_d.pay  = in_pay;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/vmi_sat_count.sv
module vmi_sat_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (inc && s_q.cnt != CNT_MAX) s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.cnt;
endmodule

// File: rtl/vupper_merge_inject.sv
module vupper_merge_inject #(
    parameter int NREG  = 16,
    parameter int PAY_W = 32,
    parameter int CNT_W = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [2:0]       in_cls,
    input  logic [IDX_W-1:0] in_dst,
    input  logic [PAY_W-1:0] in_pay,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_merge,
    output logic [2:0]       out_cls,
    output logic [IDX_W-1:0] out_dst,
    output logic             out_dep,
    output logic [PAY_W-1:0] out_pay,
    output logic [CNT_W-1:0] merge_count
);
    logic dirty_any;
    logic accept;
    logic merge_fire;

    vmi_dirty_track #(.NREG(NREG), .IDX_W(IDX_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (accept),
        .cls       (in_cls),
        .dst       (in_dst),
        .dirty_any (dirty_any)
    );

    vmi_merge_seq #(.IDX_W(IDX_W), .PAY_W(PAY_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .dirty_any  (dirty_any),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_cls     (in_cls),
        .in_dst     (in_dst),
        .in_pay     (in_pay),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_merge  (out_merge),
        .out_cls    (out_cls),
        .out_dst    (out_dst),
        .out_dep    (out_dep),
        .out_pay    (out_pay),
        .accept     (accept),
        .merge_fire (merge_fire)
    );

    vmi_sat_count #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (merge_fire),
        .count (merge_count)
    );
endmodule

// File: rtl/vmi_checker.sv
module vmi_checker #(
    parameter int IDX_W = 4,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [2:0]       in_cls,
    input logic [IDX_W-1:0] in_dst,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_merge,
    input logic [2:0]       out_cls,
    input logic [IDX_W-1:0] out_dst,
    input logic             out_dep,
    input logic [CNT_W-1:0] merge_count
);
    // R2
    merge_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_cls == 3'd0 && out_dep)
        |=> (out_valid && out_merge && out_dst == $past(in_dst)));

    // R4
    prefixed_no_dep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_merge && out_cls == 3'd1) |-> !out_dep);

    // R6
    zero_upper_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_cls == 3'd3 || in_cls == 3'd4))
        |=> !(out_valid && out_dep));

    // R8
    merge_blocks_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_merge) |-> !in_ready);

    // R8
    merge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_merge && !out_ready)
        |=> (out_valid && out_merge && $stable(out_dst)));

    // R9
    count_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (merge_count >= $past(merge_count)));
endmodule

bind vupper_merge_inject vmi_checker #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_cls      (in_cls),
    .in_dst      (in_dst),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_merge   (out_merge),
    .out_cls     (out_cls),
    .out_dst     (out_dst),
    .out_dep     (out_dep),
    .merge_count (merge_count)
);

// File: tb/vupper_merge_inject_test.sv
module vupper_merge_inject_test;
    localparam int PAY_W = 8;
    localparam int CNT_W = 3;
    localparam int CMAX  = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [2:0]       in_cls = 3'd0;
    logic [3:0]       in_dst = 4'd0;
    logic [PAY_W-1:0] in_pay = '0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic             out_merge;
    logic [2:0]       out_cls;
    logic [3:0]       out_dst;
    logic             out_dep;
    logic [PAY_W-1:0] out_pay;
    logic [CNT_W-1:0] merge_count;

    int n_chk = 0;
    int n_fail = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vupper_merge_inject #(.NREG(16), .PAY_W(PAY_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_cls(in_cls),
        .in_dst(in_dst), .in_pay(in_pay),
        .out_valid(out_valid), .out_ready(out_ready), .out_merge(out_merge),
        .out_cls(out_cls), .out_dst(out_dst), .out_dep(out_dep),
        .out_pay(out_pay), .merge_count(merge_count)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Send one instruction; check pass-through, then the merge uop if expected.
    task automatic issue(input string req, input logic [2:0] cls,
                         input logic [3:0] dst, input logic [PAY_W-1:0] pay,
                         input bit exp_merge);
        @(negedge clk);
        in_valid = 1'b1; in_cls = cls; in_dst = dst; in_pay = pay;
        #1;
        chk(req, "pass valid", {31'd0, out_valid}, 32'd1);
        chk(req, "pass merge flag", {31'd0, out_merge}, 32'd0);
        chk(req, "pass dst", {28'd0, out_dst}, {28'd0, dst});
        chk(req, "pass cls", {29'd0, out_cls}, {29'd0, cls});
        chk(req, "pass dep", {31'd0, out_dep}, {31'd0, exp_merge});
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        if (exp_merge) begin
            chk(req, "merge valid", {31'd0, out_valid}, 32'd1);
            chk(req, "merge flag", {31'd0, out_merge}, 32'd1);
            chk(req, "merge dst", {28'd0, out_dst}, {28'd0, dst});
            chk(req, "merge pay", {24'd0, out_pay}, {24'd0, pay});
            chk(req, "merge dep", {31'd0, out_dep}, 32'd1);
            chk("R8", "in_ready during merge", {31'd0, in_ready}, 32'd0);
            @(posedge clk);
            if (exp_cnt < CMAX) exp_cnt++;
            @(negedge clk);
            #1;
            chk("R9", "merge count", {29'd0, merge_count}, exp_cnt);
        end else begin
            chk(req, "no merge follows", {31'd0, out_valid}, 32'd0);
        end
    endtask

    task automatic t_reset();
        chk("R1", "reset out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1", "reset in_ready", {31'd0, in_ready}, 32'd1);
        chk("R1", "reset count", {29'd0, merge_count}, 32'd0);
        issue("R1", 3'd0, 4'd3, 8'h11, 1'b0);
    endtask

    task automatic t_wide_same();
        issue("R3", 3'd2, 4'd5, 8'h20, 1'b0);
        issue("R2", 3'd0, 4'd5, 8'h21, 1'b1);
    endtask

    task automatic t_global();
        issue("R5", 3'd0, 4'd9, 8'h30, 1'b1);
        issue("R4", 3'd1, 4'd9, 8'h31, 1'b0);
        issue("R5", 3'd0, 4'd9, 8'h32, 1'b1);
        issue("R4", 3'd1, 4'd5, 8'h33, 1'b0);
        issue("R4", 3'd0, 4'd9, 8'h34, 1'b0);
    endtask

    task automatic t_zero_upper();
        issue("R3", 3'd2, 4'd0, 8'h40, 1'b0);
        issue("R3", 3'd2, 4'd15, 8'h41, 1'b0);
        issue("R6", 3'd3, 4'd7, 8'h42, 1'b0);
        issue("R6", 3'd0, 4'd15, 8'h43, 1'b0);
    endtask

    task automatic t_zero_all();
        issue("R3", 3'd2, 4'd8, 8'h50, 1'b0);
        issue("R7", 3'd4, 4'd2, 8'h51, 1'b0);
        issue("R7", 3'd0, 4'd8, 8'h52, 1'b0);
    endtask

    task automatic t_other();
        issue("R10", 3'd5, 4'd1, 8'h60, 1'b0);
        issue("R10", 3'd6, 4'd1, 8'h61, 1'b0);
        issue("R10", 3'd0, 4'd1, 8'h62, 1'b0);
        issue("R3", 3'd2, 4'd1, 8'h63, 1'b0);
        issue("R10", 3'd7, 4'd1, 8'h64, 1'b0);
        issue("R10", 3'd0, 4'd4, 8'h65, 1'b1);
    endtask

    task automatic t_stall();
        @(negedge clk);
        in_valid = 1'b1; in_cls = 3'd0; in_dst = 4'd6; in_pay = 8'h70;
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
        in_cls = 3'd1; in_dst = 4'd12; in_pay = 8'h71;
        #1;
        chk("R8", "stall merge flag", {31'd0, out_merge}, 32'd1);
        chk("R8", "stall in_ready", {31'd0, in_ready}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        #1;
        chk("R8", "held merge flag", {31'd0, out_merge & out_valid}, 32'd1);
        chk("R8", "held merge dst", {28'd0, out_dst}, 32'd6);
        chk("R9", "count held while stalled", {29'd0, merge_count}, exp_cnt);
        out_ready = 1'b1;
        #1;
        chk("R8", "release in_ready", {31'd0, in_ready}, 32'd0);
        @(posedge clk);
        if (exp_cnt < CMAX) exp_cnt++;
        @(negedge clk);
        #1;
        chk("R8", "next instr dst", {28'd0, out_dst}, 32'd12);
        chk("R8", "next instr merge flag", {31'd0, out_merge}, 32'd0);
        chk("R9", "count after stall", {29'd0, merge_count}, exp_cnt);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 9; i++)
            issue("R9", 3'd0, 4'(i), 8'(8'h80 + i), 1'b1);
        chk("R9", "saturated count", {29'd0, merge_count}, CMAX);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_wide_same();
        t_global();
        t_zero_upper();
        t_zero_all();
        t_other();
        t_stall();
        t_saturate();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule